// File: doc/BRIEF.md
# Configuration Stream Clock-Ratio Detector

This block watches a 32-bit configuration stream word by word, as it is written, and works out the clock-to-data ratio that the configuration logic must apply to it. It counts the words from a start-of-stream pulse. At one fixed word position it takes a 2-bit encryption mode field. At a later fixed position it takes a compression flag. From these two indicators and the configuration bus width it produces a 2-bit ratio code, which software or a sequencer can program before the data path starts streaming.

The bus width (16 or 32 bits) is sampled with the start pulse. A stream that ends, marked by the last-word strobe, before the compression word has arrived cannot be classified, so it raises an error flag in place of a ratio. The result, whether a valid ratio or an error, holds until the next start pulse.

Top module: `cfg_ratio_detect`

## Requirements
- R1: A start pulse (`sos_i`) clears `ratio_vld_o`, `short_err_o` and the captured indicators. It also latches the width select. A word accepted in the same cycle as the start pulse is word index 0.
- R2: The stream counts as encrypted when bits [3:2] of word index 69 are nonzero. The same bits in any other word have no effect.
- R3: The stream counts as compressed when bit 1 of word index 229 is 0. Bit 1 of any other word has no effect.
- R4: A stream that is neither encrypted nor compressed gives code 0 (x1) at either width.
- R5: At 16-bit width (`wide_i`=0), a compressed stream gives code 2 (x4), whether or not it is encrypted. An encrypted stream that is not compressed gives code 1 (x2).
- R6: At 32-bit width (`wide_i`=1), a compressed stream gives code 3 (x8). An encrypted stream that is not compressed gives code 2 (x4).
- R7: `ratio_vld_o` is 0 while word 229 is being presented and is 1 in the cycle after word 229 is accepted. It then stays 1, with `ratio_o` unchanged, until the next start pulse.
- R8: When the last word of a stream is accepted at an index below 229, `short_err_o` rises in the next cycle and holds until the next start pulse. `short_err_o` and `ratio_vld_o` are never 1 together.
- R9: The word index saturates after 229. Streams of any length give the same result as their first 230 words.
- R10: Words presented outside a stream are ignored, with no effect on any output. This covers words before the first start pulse and words after an accepted last word.
- R11: A change of `wide_i` during a stream has no effect on that stream's code.
- R12: `ratio_o` reads 0 whenever `ratio_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sos_i | input | 1 | Start-of-stream pulse |
| word_vld_i | input | 1 | Stream word strobe |
| word_last_i | input | 1 | Marks the strobed word as the stream's last |
| word_i | input | 32 | Stream data word |
| wide_i | input | 1 | Bus width select: 1 = 32-bit, 0 = 16-bit |
| ratio_o | output | 2 | Ratio code: 0=x1, 1=x2, 2=x4, 3=x8 |
| ratio_vld_o | output | 1 | Ratio code is valid |
| short_err_o | output | 1 | Stream ended before word 229 |

## Verification
The hardest case to reach is the one after classification. Here a long stream keeps running past index 229, and a counter that wrapped or kept comparing would hit the sampling positions a second time. To reach it, every filler word carries the opposite indicator values: encryption bits set and compression bit clear. Streams several hundred words long are then sent, so any re-sample or off-by-one position changes the code. The word immediately before and after index 229 is probed for the valid timing. Single-word and 229-word streams cover the two edges of the error case.

// File: rtl/cfg_ratio_pkg.sv
`timescale 1ns/1ps
package cfg_ratio_pkg;
  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  // compressed -> x4 base, encrypted-only -> x2 base, 32-bit width doubles
  function automatic ratio_e ratio_pick(input logic enc, input logic cmp, input logic wide);
    logic [1:0] base;
    if (!enc && !cmp) return RATIO_X1;
    base = cmp ? 2'd2 : 2'd1;
    return ratio_e'(base + {1'b0, wide});
  endfunction
endpackage

// File: rtl/cfg_word_tracker.sv
`timescale 1ns/1ps
module cfg_word_tracker #(
  parameter int LAST_IDX = 229,
  parameter int IDX_W    = $clog2(LAST_IDX + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sos_i,
  input  logic             vld_i,
  input  logic             last_i,
  output logic             acc_o,
  output logic             end_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] SAT = IDX_W'(LAST_IDX + 1);

  logic             active_q;
  logic [IDX_W-1:0] cnt_q;

  assign acc_o = vld_i & (active_q | sos_i);
  assign end_o = acc_o & last_i;
  assign idx_o = sos_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
    end else if (end_o) begin
      active_q <= 1'b0;
    end else if (sos_i) begin
      active_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sos_i) begin
      cnt_q <= vld_i ? IDX_W'(1) : '0;
    end else if (acc_o && cnt_q != SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: index never passes the saturation point
  p_cnt_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT);

  // R10: no accepted word, no start -> index frozen
  p_cnt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_o && !sos_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cfg_field_capture.sv
`timescale 1ns/1ps
module cfg_field_capture #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 8,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sos_i,
  input  logic              acc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              enc_o,
  output logic              cmp_o,
  output logic              hit_cmp_o
);
  localparam logic [IDX_W-1:0] ENC_POS = IDX_W'(ENC_IDX);
  localparam logic [IDX_W-1:0] CMP_POS = IDX_W'(CMP_IDX);

  logic hit_enc;
  logic enc_q;

  assign hit_enc   = acc_i && (idx_i == ENC_POS);
  assign hit_cmp_o = acc_i && (idx_i == CMP_POS);
  // flag clear means compressed
  assign cmp_o     = ~word_i[CMP_BIT];
  assign enc_o     = enc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_q <= 1'b0;
    end else if (hit_enc) begin
      enc_q <= |word_i[ENC_LSB +: ENC_W];
    end else if (sos_i) begin
      enc_q <= 1'b0;
    end
  end

  // R2: encryption indicator moves only at its own word or a start
  p_enc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_enc && !sos_i) |=> $stable(enc_q));
endmodule

// File: rtl/cfg_ratio_encode.sv
`timescale 1ns/1ps
module cfg_ratio_encode
  import cfg_ratio_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int CMP_IDX = 229
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sos_i,
  input  logic             wide_i,
  input  logic             end_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             enc_i,
  input  logic             cmp_i,
  input  logic             hit_cmp_i,
  output logic [1:0]       ratio_o,
  output logic             ratio_vld_o,
  output logic             short_err_o
);
  localparam logic [IDX_W-1:0] CMP_POS = IDX_W'(CMP_IDX);

  logic   wide_q;
  logic   vld_q;
  logic   err_q;
  ratio_e ratio_q;
  logic   short_end;

  assign short_end = end_i && (idx_i < CMP_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wide_q <= 1'b0;
    else if (sos_i) wide_q <= wide_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      ratio_q <= RATIO_X1;
    end else if (sos_i) begin
      vld_q   <= 1'b0;
      err_q   <= short_end;
      ratio_q <= RATIO_X1;
    end else if (hit_cmp_i) begin
      vld_q   <= 1'b1;
      ratio_q <= ratio_pick(enc_i, cmp_i, wide_q);
    end else if (short_end) begin
      err_q   <= 1'b1;
    end
  end

  assign ratio_o     = ratio_q;
  assign ratio_vld_o = vld_q;
  assign short_err_o = err_q;

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_q && err_q));

  p_vld_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cmp_i |=> vld_q);

  p_vld_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !sos_i) |=> (vld_q && $stable(ratio_q)));

  p_plain_x1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cmp_i && !enc_i && !cmp_i) |=> (ratio_q == RATIO_X1));

  p_zero_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |-> (ratio_q == RATIO_X1));

  p_sos_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sos_i && !end_i) |=> (!vld_q && !err_q));

  p_wide_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sos_i |=> $stable(wide_q));
endmodule

// File: rtl/cfg_ratio_detect.sv
`timescale 1ns/1ps
module cfg_ratio_detect #(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sos_i,
  input  logic              word_vld_i,
  input  logic              word_last_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              wide_i,
  output logic [1:0]        ratio_o,
  output logic              ratio_vld_o,
  output logic              short_err_o
);
  localparam int IDX_W = $clog2(CMP_IDX + 2);

  logic             acc;
  logic             stream_end;
  logic [IDX_W-1:0] idx;
  logic             enc;
  logic             cmp;
  logic             hit_cmp;

  cfg_word_tracker #(
    .LAST_IDX (CMP_IDX),
    .IDX_W    (IDX_W)
  ) u_tracker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sos_i  (sos_i),
    .vld_i  (word_vld_i),
    .last_i (word_last_i),
    .acc_o  (acc),
    .end_o  (stream_end),
    .idx_o  (idx)
  );

  cfg_field_capture #(
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .ENC_IDX (ENC_IDX),
    .ENC_LSB (ENC_LSB),
    .ENC_W   (ENC_W),
    .CMP_IDX (CMP_IDX),
    .CMP_BIT (CMP_BIT)
  ) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sos_i     (sos_i),
    .acc_i     (acc),
    .idx_i     (idx),
    .word_i    (word_i),
    .enc_o     (enc),
    .cmp_o     (cmp),
    .hit_cmp_o (hit_cmp)
  );

  cfg_ratio_encode #(
    .IDX_W   (IDX_W),
    .CMP_IDX (CMP_IDX)
  ) u_encode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sos_i       (sos_i),
    .wide_i      (wide_i),
    .end_i       (stream_end),
    .idx_i       (idx),
    .enc_i       (enc),
    .cmp_i       (cmp),
    .hit_cmp_i   (hit_cmp),
    .ratio_o     (ratio_o),
    .ratio_vld_o (ratio_vld_o),
    .short_err_o (short_err_o)
  );
endmodule

// File: tb/cfg_ratio_detect_bench.sv
`timescale 1ns/1ps
module cfg_ratio_detect_bench;
  localparam int ENC_POS = 69;
  localparam int CMP_POS = 229;

  typedef struct {
    logic       vld;
    logic       err;
    logic [1:0] code;
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sos = 1'b0;
  logic        vld = 1'b0;
  logic        last = 1'b0;
  logic [31:0] word = '0;
  logic        wide = 1'b0;
  logic [1:0]  ratio;
  logic        ratio_vld;
  logic        short_err;

  int   total = 0;
  int   bad = 0;
  exp_t sb_q[$];
  event chk_ev;

  always #2.5 clk = ~clk;

  cfg_ratio_detect u_cfg_ratio_detect (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sos_i       (sos),
    .word_vld_i  (vld),
    .word_last_i (last),
    .word_i      (word),
    .wide_i      (wide),
    .ratio_o     (ratio),
    .ratio_vld_o (ratio_vld),
    .short_err_o (short_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input logic [1:0] enc, input logic flag, input logic w);
    if (enc == 2'b00 && flag) return 2'd0;
    return (flag ? 2'd1 : 2'd2) + {1'b0, w};
  endfunction

  // filler words carry the opposite indicators: enc bits 11, flag bit 0
  function automatic logic [31:0] filler(input int i);
    logic [31:0] f;
    f = 32'(i) * 32'h9E37_79B1;
    return {f[31:4], 4'b1101};
  endfunction

  task automatic run_stream(input int n, input logic [1:0] enc, input logic flag,
                            input logic w, input bit flip, input string req);
    exp_t e;
    e.vld  = (n > CMP_POS);
    e.err  = (n <= CMP_POS);
    e.code = e.vld ? exp_code(enc, flag, w) : 2'd0;
    e.req  = req;
    sb_q.push_back(e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 1) begin
        chk(ratio_vld == 1'b0 && short_err == 1'b0, "R1 clear after start", {ratio_vld, short_err}, 0);
        chk(ratio == 2'd0, "R12 code zero while pending", ratio, 0);
      end
      if (i == CMP_POS) chk(ratio_vld == 1'b0, "R7 not valid before word 229", ratio_vld, 0);
      if (i == CMP_POS + 1) chk(ratio_vld == 1'b1, "R7 valid after word 229", ratio_vld, 1);
      sos  = (i == 0);
      vld  = 1'b1;
      last = (i == n - 1);
      word = filler(i);
      if (i == 0) wide = w;
      if (flip && i == 100) wide = ~w;
      if (i == ENC_POS) word[3:2] = enc;
      if (i == CMP_POS) word[1] = flag;
    end
    @(negedge clk);
    sos = 1'b0; vld = 1'b0; last = 1'b0;
    -> chk_ev;
    #0.1;
  endtask

  // words with no start pulse
  task automatic loose_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld  = 1'b1;
      last = (i % 7 == 3);
      word = (i == ENC_POS || i == CMP_POS) ? 32'h0000_0000 : filler(i);
    end
    @(negedge clk);
    vld = 1'b0; last = 1'b0;
  endtask

  // monitor: pops expected result and compares when the driver marks a stream end
  initial begin
    forever begin
      exp_t e;
      @(chk_ev);
      if (sb_q.size() == 0) begin
        chk(1'b0, "scoreboard underflow", 0, 1);
      end else begin
        e = sb_q.pop_front();
        chk(ratio_vld == e.vld, {e.req, " valid"}, ratio_vld, e.vld);
        chk(short_err == e.err, {e.req, " error"}, short_err, e.err);
        chk(ratio == e.code, {e.req, " code"}, ratio, e.code);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ratio_vld == 1'b0 && short_err == 1'b0 && ratio == 2'd0, "reset state", {ratio_vld, short_err, ratio}, 0);
    rst_ni = 1'b1;

    // R10: words before any start
    loose_words(300);
    chk(ratio_vld == 1'b0 && short_err == 1'b0, "R10 words before start ignored", {ratio_vld, short_err}, 0);

    run_stream(230, 2'b00, 1'b1, 1'b0, 1'b0, "R4 plain 16-bit");
    run_stream(230, 2'b01, 1'b1, 1'b0, 1'b0, "R5 R2 encrypted 16-bit");
    run_stream(230, 2'b10, 1'b0, 1'b0, 1'b0, "R5 R3 enc+cmp 16-bit");
    run_stream(230, 2'b00, 1'b0, 1'b0, 1'b0, "R5 R3 compressed 16-bit");
    run_stream(230, 2'b00, 1'b1, 1'b1, 1'b0, "R4 plain 32-bit");
    run_stream(230, 2'b11, 1'b1, 1'b1, 1'b0, "R6 encrypted 32-bit");
    run_stream(230, 2'b00, 1'b0, 1'b1, 1'b0, "R6 compressed 32-bit");
    run_stream(230, 2'b01, 1'b0, 1'b1, 1'b0, "R6 enc+cmp 32-bit");

    // R9: long streams, filler past 229 would flip the result if re-sampled
    run_stream(600, 2'b00, 1'b1, 1'b1, 1'b0, "R9 long plain");
    run_stream(520, 2'b00, 1'b1, 1'b0, 1'b0, "R9 long plain 16-bit");

    // R11: width flipped mid-stream
    run_stream(230, 2'b10, 1'b1, 1'b1, 1'b1, "R11 width change ignored 32");
    run_stream(230, 2'b00, 1'b0, 1'b0, 1'b1, "R11 width change ignored 16");

    // R8: short streams
    run_stream(229, 2'b01, 1'b0, 1'b1, 1'b0, "R8 stream of 229 words");
    // R10: words after the last one must not change the error or make a ratio
    loose_words(300);
    chk(short_err == 1'b1 && ratio_vld == 1'b0 && ratio == 2'd0, "R10 words after end ignored",
        {short_err, ratio_vld, ratio}, 4'b1000);
    run_stream(1, 2'b00, 1'b1, 1'b0, 1'b0, "R8 single-word stream");
    run_stream(70, 2'b11, 1'b1, 1'b0, 1'b0, "R8 stream of 70 words");

    // R1: new stream after an error clears it and classifies again
    run_stream(230, 2'b11, 1'b0, 1'b1, 1'b0, "R1 restart after error");

    // R7: held with no further words
    repeat (20) @(negedge clk);
    chk(ratio_vld == 1'b1 && ratio == 2'd3, "R7 result held", {ratio_vld, ratio}, 7);

    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule